// File: doc/BRIEF.md
# Keyed Watchdog Timer

The block is a watchdog timer that sits on a small register bus. A down counter is advanced by a tick taken from a free-running prescaler of the master clock. Software has to restart the counter at regular intervals. If it fails to, the counter runs out and the block raises any mix of three overflow actions:

- a one-cycle internal reset request;
- a one-cycle interrupt pulse;
- an active-low overflow pin held low for a fixed number of master clock cycles.

Every write to a mode or command register carries a 16-bit key in its upper half. The write only takes effect when that key matches the register's own key value. A stray write from runaway code therefore cannot disable or restart the watchdog.

Software sets the reload value's upper nibble and the tick rate in the tick register. It enables counting and the overflow actions in the action register, and restarts the counter through the command register. A sticky status flag records that an overflow has happened.

Top module: `wdt_keyed`

## Requirements
- R1: After reset, core_rst_pulse and irq_pulse are 0 and ovf_pin_n is 1. The action register (address 0x0), the tick register (0x4) and the status register (0xC) all read 0.
- R2: A write takes effect only if bus_wdata[31:16] holds that register's key: 16'hA5C3 for the action register, 16'h3C96 for the tick register, 16'hD17E for the command register (0x8). A write with any other key changes nothing.
- R3: The reload value is {nibble, all ones in the low CNT_W-NIB_W bits}. The counter is loaded with it on every keyed command write and on every keyed tick register write, using the newly written nibble.
- R4: Tick select s (0..3) gives one tick every 2^TAP[s] master clock cycles. The counter only moves while the run bit is set. A tick arriving at count 0 is an overflow and reloads the counter, so overflows repeat every (reload+1)*2^TAP[s] cycles.
- R5: With the interrupt enable set, each overflow gives irq_pulse high for exactly one cycle.
- R6: With the reset enable set, each overflow gives core_rst_pulse high for exactly one cycle, in the same cycle as the interrupt pulse. With the enable clear, core_rst_pulse stays 0.
- R7: With the pin enable set, each overflow drives ovf_pin_n low for exactly PULSE_LEN (8) cycles, starting in the cycle of the interrupt pulse. With the enable clear, ovf_pin_n stays 1.
- R8: Status bit 0 is set by an overflow and stays set. A read of address 0xC returns it and clears it for the following reads.
- R9: Action register layout: bit 0 run, bit 1 reset enable, bit 2 interrupt enable, bit 3 pin enable. Tick register layout: bits 1:0 tick select, bits 2+NIB_W-1:2 nibble. The command register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Byte address; bits 3:2 select the register |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data; key in bits 31:16 |
| bus_rdata | output | 32 | Read data for the addressed register |
| core_rst_pulse | output | 1 | Internal reset request on overflow |
| irq_pulse | output | 1 | Interrupt pulse on overflow |
| ovf_pin_n | output | 1 | Active-low overflow pin |

## Verification
The timeout is checked over every combination of tick select and reload nibble. The bench measures the spacing of consecutive interrupt pulses and compares it with (reload+1)*2^TAP, so an error in the nibble position, in a prescaler tap or in the underflow reload each gives a different wrong spacing. The keys are tried both right and off by one bit:

- on the mode registers, by reading them back;
- on the command register, where good restarts must suppress every overflow and bad ones must not.

A long-period run with all actions enabled measures the pulse widths and their alignment. An interrupt-only run shows that the other two actions stay quiet. A run with the run bit clear must produce no overflow at all.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;

    typedef enum logic [1:0] {
        REG_ACT  = 2'd0,
        REG_TICK = 2'd1,
        REG_CMD  = 2'd2,
        REG_STAT = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic pin_en;
        logic irq_en;
        logic rst_en;
        logic run;
    } act_t;

    localparam logic [15:0] KEY_ACT  = 16'hA5C3;
    localparam logic [15:0] KEY_TICK = 16'h3C96;
    localparam logic [15:0] KEY_CMD  = 16'hD17E;

endpackage

// File: rtl/wdt_keyed_regs.sv
module wdt_keyed_regs
    import wdt_keyed_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic             ovf_ev,
    output act_t             act,
    output logic [1:0]       sel,
    output logic [NIB_W-1:0] nib_cur,
    output logic [NIB_W-1:0] nib_next,
    output logic             reload_req
);

    typedef struct packed {
        act_t             act;
        logic [1:0]       sel;
        logic [NIB_W-1:0] nib;
        logic             flag;
    } regs_t;

    regs_t       s_d, s_q;
    reg_sel_e    rsel;
    logic [15:0] key;

    always_comb begin
        s_d        = s_q;
        reload_req = 1'b0;
        rsel       = reg_sel_e'(bus_addr[3:2]);
        key        = bus_wdata[31:16];
        if (bus_wr) begin
            case (rsel)
                REG_ACT: if (key == KEY_ACT) s_d.act = act_t'(bus_wdata[3:0]);
                REG_TICK: if (key == KEY_TICK) begin
                    s_d.sel    = bus_wdata[1:0];
                    s_d.nib    = bus_wdata[2 +: NIB_W];
                    reload_req = 1'b1;
                end
                REG_CMD: if (key == KEY_CMD) reload_req = 1'b1;
                default: ;
            endcase
        end
        s_d.flag = ovf_ev | (s_q.flag & ~(bus_rd && rsel == REG_STAT));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (rsel)
            REG_ACT:  bus_rdata[3:0] = s_q.act;
            REG_TICK: begin
                bus_rdata[1:0]        = s_q.sel;
                bus_rdata[2 +: NIB_W] = s_q.nib;
            end
            REG_STAT: bus_rdata[0] = s_q.flag;
            default:  bus_rdata = '0;
        endcase
    end

    assign act      = s_q.act;
    assign sel      = s_q.sel;
    assign nib_cur  = s_q.nib;
    assign nib_next = s_d.nib;

    assert_bad_key_act_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[3:2] == 2'd0 && bus_wdata[31:16] != KEY_ACT) |=> $stable(act));

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_ev |=> bus_rd || (bus_addr[3:2] != 2'd3) || s_q.flag);

endmodule

// File: rtl/wdt_keyed_prescale.sv
module wdt_keyed_prescale #(
    parameter int PRE_W  = 12,
    parameter int TAP[4] = '{5, 7, 10, 12}
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    output logic       tick
);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_t;

    pre_t       s_d, s_q;
    logic [3:0] taps;

    for (genvar i = 0; i < 4; i++) begin : g_tap
        assign taps[i] = &s_q.pre[TAP[i]-1:0];
    end

    always_comb begin
        s_d     = s_q;
        s_d.pre = s_q.pre + 1'b1;
        tick    = taps[sel];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/wdt_keyed_count.sv
module wdt_keyed_count #(
    parameter int CNT_W = 16,
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             load,
    input  logic [NIB_W-1:0] nib,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf_ev
);

    localparam int LOW_W = CNT_W - NIB_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t             s_d, s_q;
    logic [CNT_W-1:0] reload;

    always_comb begin
        s_d    = s_q;
        ovf_ev = 1'b0;
        reload = {nib, {LOW_W{1'b1}}};
        if (load) begin
            s_d.cnt = reload;
        end else if (run && tick) begin
            if (s_q.cnt == '0) begin
                ovf_ev  = 1'b1;
                s_d.cnt = reload;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{cnt: {{NIB_W{1'b0}}, {LOW_W{1'b1}}}};
        else        s_q <= s_d;
    end

    assign cnt = s_q.cnt;

    assert_hold_when_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(cnt));

endmodule

// File: rtl/wdt_keyed_actions.sv
module wdt_keyed_actions
    import wdt_keyed_pkg::*;
#(
    parameter int PULSE_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf_ev,
    input  act_t act,
    output logic core_rst_pulse,
    output logic irq_pulse,
    output logic ovf_pin_n
);

    localparam int PW = $clog2(PULSE_LEN + 1);

    typedef struct packed {
        logic          rst;
        logic          irq;
        logic [PW-1:0] ext;
    } out_t;

    out_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.rst = ovf_ev & act.rst_en;
        s_d.irq = ovf_ev & act.irq_en;
        if (ovf_ev && act.pin_en)  s_d.ext = PW'(PULSE_LEN);
        else if (s_q.ext != '0)    s_d.ext = s_q.ext - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign core_rst_pulse = s_q.rst;
    assign irq_pulse      = s_q.irq;
    assign ovf_pin_n      = (s_q.ext == '0);

    logic [7:0] low_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n || ovf_pin_n) low_run_q <= '0;
        else if (low_run_q != 8'hFF) low_run_q <= low_run_q + 1'b1;
    end

    assert_irq_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    assert_rst_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_pulse |=> !core_rst_pulse);

    assert_pin_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_pin_n) |-> low_run_q >= 8'(PULSE_LEN));

endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
    import wdt_keyed_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int NIB_W     = 4,
    parameter int PRE_W     = 12,
    parameter int TAP[4]    = '{5, 7, 10, 12},
    parameter int PULSE_LEN = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        core_rst_pulse,
    output logic        irq_pulse,
    output logic        ovf_pin_n
);

    localparam int LOW_W = CNT_W - NIB_W;

    act_t             act;
    logic [1:0]       sel;
    logic [NIB_W-1:0] nib_cur, nib_next;
    logic             reload_req, tick, ovf_ev;
    logic [CNT_W-1:0] cnt;

    wdt_keyed_regs #(.NIB_W(NIB_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ovf_ev(ovf_ev), .act(act), .sel(sel), .nib_cur(nib_cur),
        .nib_next(nib_next), .reload_req(reload_req)
    );

    wdt_keyed_prescale #(.PRE_W(PRE_W), .TAP(TAP)) u_pre (
        .clk(clk), .rst_n(rst_n), .sel(sel), .tick(tick)
    );

    wdt_keyed_count #(.CNT_W(CNT_W), .NIB_W(NIB_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(act.run),
        .load(reload_req), .nib(nib_next), .cnt(cnt), .ovf_ev(ovf_ev)
    );

    wdt_keyed_actions #(.PULSE_LEN(PULSE_LEN)) u_act (
        .clk(clk), .rst_n(rst_n), .ovf_ev(ovf_ev), .act(act),
        .core_rst_pulse(core_rst_pulse), .irq_pulse(irq_pulse), .ovf_pin_n(ovf_pin_n)
    );

    assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= {nib_cur, {LOW_W{1'b1}}});

endmodule

// File: tb/test_wdt_keyed.sv
module test_wdt_keyed;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        core_rst_pulse, irq_pulse, ovf_pin_n;

    int n_cmp = 0, n_bad = 0;
    int cyc = 0;
    int irq_cnt = 0;
    int rst_seen = 0;
    int pin_seen = 0;

    always #2.5 clk = ~clk;

    wdt_keyed #(.CNT_W(6), .NIB_W(4), .PRE_W(4), .TAP('{1, 2, 3, 4}), .PULSE_LEN(8)) i_wdt_keyed (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_rst_pulse(core_rst_pulse),
        .irq_pulse(irq_pulse), .ovf_pin_n(ovf_pin_n)
    );

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) begin
        if (rst_n && irq_pulse)       irq_cnt  <= irq_cnt + 1;
        if (rst_n && core_rst_pulse)  rst_seen <= rst_seen + 1;
        if (rst_n && !ovf_pin_n)      pin_seen <= pin_seen + 1;
    end

    task automatic check(input string req, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] k, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = {k, d}; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_irq(output int t, input int lim);
        t = -1;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (irq_pulse) begin t = cyc; return; end
        end
    endtask

    initial begin
        #2_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int t1, t2, base, low;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 core_rst_pulse", core_rst_pulse, 0);
        check("R1 irq_pulse", irq_pulse, 0);
        check("R1 ovf_pin_n", ovf_pin_n, 1);
        rd(4'h0, d); check("R1 action reg", d, 0);
        rd(4'h4, d); check("R1 tick reg", d, 0);
        rd(4'hC, d); check("R1 status reg", d, 0);

        // R2 wrong keys ignored
        wr(4'h0, 16'hA5C2, 16'h000F); rd(4'h0, d); check("R2 bad key action", d, 0);
        wr(4'h4, 16'h3C97, 16'h003F); rd(4'h4, d); check("R2 bad key tick", d, 0);
        // R9 layout readback
        wr(4'h0, 16'hA5C3, 16'h000E); rd(4'h0, d); check("R9 action readback", d, 32'hE);
        wr(4'h4, 16'h3C96, 16'h002A); rd(4'h4, d); check("R9 tick readback", d, 32'h2A);
        rd(4'h8, d); check("R9 command reads 0", d, 0);
        wr(4'h0, 16'hA5C3, 16'h0000);

        // R4 run bit clear: no overflow
        wr(4'h4, 16'h3C96, 16'h0000);
        wr(4'h0, 16'hA5C3, 16'h0004);
        base = irq_cnt;
        repeat (600) @(negedge clk);
        check("R4 no overflow while stopped", irq_cnt - base, 0);
        rd(4'hC, d); check("R8 status clear without overflow", d, 0);

        // R3/R4 sweep of tick select and nibble: overflow spacing
        for (int s = 0; s < 4; s++) begin
            for (int n = 0; n < 16; n++) begin
                wr(4'h4, 16'h3C96, 16'((n << 2) | s));
                wr(4'h0, 16'hA5C3, 16'h0005);
                wait_irq(t1, 3000);
                wait_irq(t2, 3000);
                check($sformatf("R4 R3 period sel%0d nib%0d", s, n), t2 - t1, (n * 4 + 4) << (s + 1));
                wr(4'h0, 16'hA5C3, 16'h0000);
            end
        end
        rd(4'hC, d);

        // R5/R6/R7 pulse shapes, all actions enabled, long period
        wr(4'h4, 16'h3C96, 16'h000F);
        wr(4'h0, 16'hA5C3, 16'h000F);
        wait_irq(t1, 3000);
        check("R5 irq seen", t1 >= 0, 1);
        check("R6 reset with irq", core_rst_pulse, 1);
        low = 0;
        while (!ovf_pin_n && low < 40) begin low++; @(negedge clk); end
        check("R7 pin low width", low, 8);
        wr(4'h0, 16'hA5C3, 16'h0000);
        // R8 status sticky then cleared on read
        repeat (20) @(negedge clk);
        rd(4'hC, d); check("R8 status set", d, 1);
        rd(4'hC, d); check("R8 status cleared by read", d, 0);
        // R5 single cycle width
        wr(4'h4, 16'h3C96, 16'h0003);
        wr(4'h0, 16'hA5C3, 16'h0007);
        wait_irq(t1, 3000);
        @(negedge clk);
        check("R5 irq one cycle", irq_pulse, 0);
        check("R6 reset one cycle", core_rst_pulse, 0);
        wr(4'h0, 16'hA5C3, 16'h0000);

        // R6/R7 disabled actions stay quiet
        wr(4'h4, 16'h3C96, 16'h0000);
        base = rst_seen; low = pin_seen; t2 = irq_cnt;
        wr(4'h0, 16'hA5C3, 16'h0005);
        repeat (100) @(negedge clk);
        wr(4'h0, 16'hA5C3, 16'h0000);
        check("R5 irq occurred", irq_cnt > t2, 1);
        check("R6 reset disabled", rst_seen - base, 0);
        check("R7 pin disabled", pin_seen - low, 0);

        // R2/R3 restart with good key holds off overflow; bad key does not
        wr(4'h4, 16'h3C96, 16'h003C);
        wr(4'h0, 16'hA5C3, 16'h0005);
        base = irq_cnt;
        for (int i = 0; i < 15; i++) begin
            repeat (40) @(negedge clk);
            wr(4'h8, 16'hD17E, 16'h0000);
        end
        check("R3 good restart prevents overflow", irq_cnt - base, 0);
        base = irq_cnt;
        for (int i = 0; i < 15; i++) begin
            repeat (40) @(negedge clk);
            wr(4'h8, 16'hD17F, 16'h0000);
        end
        check("R2 bad restart key ignored", irq_cnt > base, 1);
        wr(4'h0, 16'hA5C3, 16'h0000);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule